// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a set of peripheral interrupt sources and a CPU. It latches each request and gates it with that source's enable bit. A source is eligible only when its priority level is above the priority the CPU is running at. Of the eligible sources, only the highest-priority one is offered to the CPU. A separate non-maskable request outranks every source and is never gated by enables or by the CPU priority.

An interrupt is offered only when the CPU signals an instruction boundary. The CPU takes it by raising acknowledge. The controller then drives an acknowledge line to the chosen device and waits for that device to return a vector. The vector selects the handler entry that the CPU calls. If no vector comes back within a set number of cycles, the controller signals a bus error instead and returns to idle.

Source `i` (numbered 0 to `N_SRC-1`) has priority level `i+1`. A higher index therefore means higher priority, and a CPU priority of 0 lets every enabled source through.

Top module: `irq_vec_ctrl`

## Requirements
- R1: When several eligible sources are pending at once, `irq_id` carries the index of the highest-indexed one.
- R2: Source `i` is eligible only while `i+1 > cpu_prio`. A source that is not eligible stays pending and is offered once `cpu_prio` falls below its level.
- R3: A pending non-maskable request wins over every source regardless of `src_en` and `cpu_prio`. It is offered with `irq_nmi=1`, and it acknowledges the device through `nmi_ack`.
- R4: A request on a source whose `src_en` bit is 0 is not latched. Clearing an enable bit drops that source's pending request, so nothing is offered for it afterwards.
- R5: `irq_req` stays high until `cpu_ack` is sampled. From the next cycle until the vector arrives or the timeout expires, exactly the granted source's bit of `dev_ack_oh` is high, or `nmi_ack` for the non-maskable request.
- R6: If `dev_vec_valid` is not seen within `TIMEOUT_CYC` cycles after acknowledge, `bus_err` pulses for one cycle, no vector is produced, and the controller returns to idle with the request still pending.
- R7: A new request is raised only in a cycle that follows an edge where `insn_boundary` was 1. While `insn_boundary` is 0, `irq_req` stays low.
- R8: When `dev_vec_valid` is seen while waiting, `vec_valid` is high for exactly one cycle with `vec` equal to the returned `dev_vec`, and the granted request is cleared.
- R9: A request pulse of one cycle on an enabled source stays latched until it is serviced, however long the wait.
- R10: After reset, `irq_req`, `dev_ack_oh`, `nmi_ack`, `vec_valid` and `bus_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | N_SRC | Request pulses or levels from the sources |
| src_en | input | N_SRC | Per-source enable bits |
| nmi_req | input | 1 | Non-maskable request |
| cpu_prio | input | $clog2(N_SRC+1) | Priority the CPU currently runs at |
| insn_boundary | input | 1 | High between instructions |
| irq_req | output | 1 | Interrupt offered to the CPU |
| irq_nmi | output | 1 | Offered interrupt is the non-maskable one |
| irq_id | output | $clog2(N_SRC) | Index of the offered source |
| cpu_ack | input | 1 | CPU takes the offered interrupt |
| dev_ack_oh | output | N_SRC | One-hot acknowledge to the granted source |
| nmi_ack | output | 1 | Acknowledge to the non-maskable requester |
| dev_vec_valid | input | 1 | Device presents its vector |
| dev_vec | input | VEC_W | Vector from the device |
| vec_valid | output | 1 | One-cycle strobe for `vec` |
| vec | output | VEC_W | Accepted vector, the handler table index |
| bus_err | output | 1 | One-cycle pulse on a vector timeout |

## Verification
The bench builds the controller with four sources and a timeout of five cycles. With four sources, every CPU priority from "all open" to "all masked" (0 to 4) can be swept. A three-way contention can also be drained in order. The short timeout lets a bus error be forced and then retried within a few cycles.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_REQ  = 2'd1,
    HS_WAIT = 2'd2
  } hs_state_t;
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_req,
  input  logic [N_SRC-1:0] src_en,
  input  logic             nmi_req,
  input  logic [N_SRC-1:0] clr_src,
  input  logic             clr_nmi,
  output logic [N_SRC-1:0] pend,
  output logic             nmi_pend
);
  logic [N_SRC-1:0] pend_q, pend_d;
  logic             nmi_q, nmi_d;

  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    always_comb begin
      pend_d[i] = src_en[i] & ~clr_src[i] & (pend_q[i] | src_req[i]);
    end
  end

  always_comb begin
    nmi_d = ~clr_nmi & (nmi_q | nmi_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      nmi_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      nmi_q  <= nmi_d;
    end
  end

  assign pend     = pend_q;
  assign nmi_pend = nmi_q;

  // R4: nothing stays pending on a source that was disabled at the last edge
  p_drop_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pend_q & ~$past(src_en)) == '0));

  // R9: a latched request survives until its clear strobe
  p_hold_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != '0 && (clr_src & pend_q) == '0 && (src_en & pend_q) == pend_q)
      |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  // R3: the non-maskable request is kept until served
  p_nmi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_q && !clr_nmi) |=> nmi_q);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_SRC = 8,
  parameter int IDW   = 3,
  parameter int PW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] pend,
  input  logic [N_SRC-1:0] src_en,
  input  logic             nmi_pend,
  input  logic [PW-1:0]    cpu_prio,
  output logic             cand_valid,
  output logic             cand_nmi,
  output logic [IDW-1:0]   cand_id
);
  logic [N_SRC-1:0] elig;
  logic [IDW-1:0]   top_id;

  for (genvar i = 0; i < N_SRC; i++) begin : g_elig
    always_comb begin
      elig[i] = pend[i] & src_en[i] & (PW'(i + 1) > cpu_prio);
    end
  end

  always_comb begin
    top_id = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i]) top_id = IDW'(i);
    end
  end

  always_comb begin
    cand_nmi   = nmi_pend;
    cand_valid = nmi_pend | (|elig);
    cand_id    = nmi_pend ? '0 : top_id;
  end

  // R1: the candidate is eligible and nothing above it is
  p_highest_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && !cand_nmi) |-> ((elig >> cand_id) == N_SRC'(1)));

  // R2: a source at or below the CPU level never becomes the candidate
  p_prio_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && !cand_nmi) |-> ((PW'(cand_id) + PW'(1)) > cpu_prio));

  // R3: a pending non-maskable request always owns the candidate slot
  p_nmi_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend |-> (cand_valid && cand_nmi));
endmodule

// File: rtl/irq_handshake.sv
module irq_handshake
  import irq_pkg::*;
#(
  parameter int N_SRC       = 8,
  parameter int IDW         = 3,
  parameter int VEC_W       = 8,
  parameter int TIMEOUT_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cand_valid,
  input  logic             cand_nmi,
  input  logic [IDW-1:0]   cand_id,
  input  logic             insn_boundary,
  input  logic             cpu_ack,
  input  logic             dev_vec_valid,
  input  logic [VEC_W-1:0] dev_vec,
  output logic             irq_req,
  output logic             irq_nmi,
  output logic [IDW-1:0]   irq_id,
  output logic [N_SRC-1:0] dev_ack_oh,
  output logic             nmi_ack,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec,
  output logic             bus_err,
  output logic [N_SRC-1:0] clr_src,
  output logic             clr_nmi
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  hs_state_t        state_q, state_d;
  logic [IDW-1:0]   gid_q;
  logic             gnmi_q;
  logic [CW-1:0]    cnt_q;
  logic [VEC_W-1:0] vec_q;
  logic             vval_q, berr_q;
  logic             grant_load, cnt_clr, cnt_inc, accept, expire;

  always_comb begin
    state_d    = state_q;
    grant_load = 1'b0;
    cnt_clr    = 1'b0;
    cnt_inc    = 1'b0;
    accept     = 1'b0;
    expire     = 1'b0;
    case (state_q)
      HS_IDLE: begin
        if (insn_boundary && cand_valid) begin
          state_d    = HS_REQ;
          grant_load = 1'b1;
        end
      end
      HS_REQ: begin
        if (cpu_ack) begin
          state_d = HS_WAIT;
          cnt_clr = 1'b1;
        end
      end
      HS_WAIT: begin
        if (dev_vec_valid) begin
          accept  = 1'b1;
          state_d = HS_IDLE;
        end else if (cnt_q == LAST) begin
          expire  = 1'b1;
          state_d = HS_IDLE;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
      gid_q   <= '0;
      gnmi_q  <= 1'b0;
      cnt_q   <= '0;
      vec_q   <= '0;
      vval_q  <= 1'b0;
      berr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (grant_load) begin
        gid_q  <= cand_id;
        gnmi_q <= cand_nmi;
      end
      if (cnt_clr) begin
        cnt_q <= '0;
      end else if (cnt_inc) begin
        cnt_q <= cnt_q + CW'(1);
      end
      if (accept) begin
        vec_q <= dev_vec;
      end
      vval_q <= accept;
      berr_q <= expire;
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_ack
    always_comb begin
      dev_ack_oh[i] = (state_q == HS_WAIT) && !gnmi_q && (gid_q == IDW'(i));
      clr_src[i]    = accept && !gnmi_q && (gid_q == IDW'(i));
    end
  end

  always_comb begin
    irq_req = (state_q == HS_REQ);
    irq_nmi = (state_q == HS_REQ) && gnmi_q;
    irq_id  = gid_q;
    nmi_ack = (state_q == HS_WAIT) && gnmi_q;
    clr_nmi = accept && gnmi_q;
  end

  assign vec_valid = vval_q;
  assign vec       = vec_q;
  assign bus_err   = berr_q;

  // R5: the offer is held until the CPU takes it
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !cpu_ack) |=> irq_req);

  // R5: taking the offer acknowledges exactly one requester
  p_ack_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && cpu_ack) |=> ($countones({dev_ack_oh, nmi_ack}) == 1));

  // R7: a fresh offer needs an instruction boundary at the edge that raised it
  p_boundary_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(insn_boundary));

  // R6: the wait counter never passes the timeout
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_WAIT) |-> (cnt_q < CW'(TIMEOUT_CYC)));

  // R6: bus error is a single-cycle pulse and never coincides with a vector
  p_err_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> !bus_err);
  p_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_err && vec_valid));

  // R8: the vector strobe lasts one cycle and carries the device vector
  p_vec_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);
  p_vec_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_vec_valid && (dev_ack_oh != '0 || nmi_ack)) |=> (vec_valid && vec == $past(dev_vec)));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int N_SRC       = 8,
  parameter int VEC_W       = 8,
  parameter int TIMEOUT_CYC = 16,
  localparam int IDW        = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int PW         = $clog2(N_SRC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_req,
  input  logic [N_SRC-1:0] src_en,
  input  logic             nmi_req,
  input  logic [PW-1:0]    cpu_prio,
  input  logic             insn_boundary,
  output logic             irq_req,
  output logic             irq_nmi,
  output logic [IDW-1:0]   irq_id,
  input  logic             cpu_ack,
  output logic [N_SRC-1:0] dev_ack_oh,
  output logic             nmi_ack,
  input  logic             dev_vec_valid,
  input  logic [VEC_W-1:0] dev_vec,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec,
  output logic             bus_err
);
  logic [N_SRC-1:0] pend, clr_src;
  logic             nmi_pend, clr_nmi;
  logic             cand_valid, cand_nmi;
  logic [IDW-1:0]   cand_id;

  irq_pending #(.N_SRC(N_SRC)) u_pending (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_req  (src_req),
    .src_en   (src_en),
    .nmi_req  (nmi_req),
    .clr_src  (clr_src),
    .clr_nmi  (clr_nmi),
    .pend     (pend),
    .nmi_pend (nmi_pend)
  );

  irq_arbiter #(.N_SRC(N_SRC), .IDW(IDW), .PW(PW)) u_arbiter (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend       (pend),
    .src_en     (src_en),
    .nmi_pend   (nmi_pend),
    .cpu_prio   (cpu_prio),
    .cand_valid (cand_valid),
    .cand_nmi   (cand_nmi),
    .cand_id    (cand_id)
  );

  irq_handshake #(
    .N_SRC(N_SRC), .IDW(IDW), .VEC_W(VEC_W), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_handshake (
    .clk           (clk),
    .rst_n         (rst_n),
    .cand_valid    (cand_valid),
    .cand_nmi      (cand_nmi),
    .cand_id       (cand_id),
    .insn_boundary (insn_boundary),
    .cpu_ack       (cpu_ack),
    .dev_vec_valid (dev_vec_valid),
    .dev_vec       (dev_vec),
    .irq_req       (irq_req),
    .irq_nmi       (irq_nmi),
    .irq_id        (irq_id),
    .dev_ack_oh    (dev_ack_oh),
    .nmi_ack       (nmi_ack),
    .vec_valid     (vec_valid),
    .vec           (vec),
    .bus_err       (bus_err),
    .clr_src       (clr_src),
    .clr_nmi       (clr_nmi)
  );

  // R10: the block is quiet in the first cycle after reset
  p_reset_quiet_r10: assert property (@(posedge clk)
    $rose(rst_n) |-> (!irq_req && !nmi_ack && dev_ack_oh == '0 && !vec_valid && !bus_err));
endmodule

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;
  localparam int N   = 4;
  localparam int VW  = 8;
  localparam int TMO = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  src_req, src_en;
  logic          nmi_req, insn_boundary, cpu_ack, dev_vec_valid;
  logic [2:0]    cpu_prio;
  logic [VW-1:0] dev_vec;
  logic          irq_req, irq_nmi, nmi_ack, vec_valid, bus_err;
  logic [1:0]    irq_id;
  logic [N-1:0]  dev_ack_oh;
  logic [VW-1:0] vec;

  typedef struct packed { logic err; logic [VW-1:0] v; } exp_t;
  exp_t sb[$];
  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  irq_vec_ctrl #(.N_SRC(N), .VEC_W(VW), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
    .nmi_req(nmi_req), .cpu_prio(cpu_prio), .insn_boundary(insn_boundary),
    .irq_req(irq_req), .irq_nmi(irq_nmi), .irq_id(irq_id), .cpu_ack(cpu_ack),
    .dev_ack_oh(dev_ack_oh), .nmi_ack(nmi_ack), .dev_vec_valid(dev_vec_valid),
    .dev_vec(dev_vec), .vec_valid(vec_valid), .vec(vec), .bus_err(bus_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every vector strobe or bus error
  always @(negedge clk) begin
    if (rst_n && (vec_valid || bus_err)) begin
      if (sb.size() == 0) begin
        chk("R6/R8 unexpected result", {bus_err, vec_valid}, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk("R6 bus_err kind", {31'd0, bus_err}, {31'd0, e.err});
        chk("R8 vec_valid kind", {31'd0, vec_valid}, {31'd0, ~e.err});
        if (!e.err) chk("R8 vector value", {24'd0, vec}, {24'd0, e.v});
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic pulse(input logic [N-1:0] m, input logic nmi);
    src_req = m; nmi_req = nmi;
    tick();
    src_req = '0; nmi_req = 1'b0;
  endtask

  // boundary, offer check, CPU acknowledge, device-ack check
  task automatic take(input string tag, input int id, input logic nmi);
    insn_boundary = 1'b1;
    tick();
    insn_boundary = 1'b0;
    @(negedge clk);
    chk({tag, " R7 irq_req"}, {31'd0, irq_req}, 1);
    chk({tag, " R1 irq_nmi"}, {31'd0, irq_nmi}, {31'd0, nmi});
    if (!nmi) chk({tag, " R1 irq_id"}, {30'd0, irq_id}, id);
    tick();
    chk({tag, " R5 held before ack"}, {31'd0, irq_req}, 1);
    cpu_ack = 1'b1;
    tick();
    cpu_ack = 1'b0;
    @(negedge clk);
    chk({tag, " R5 dev_ack_oh"}, {28'd0, dev_ack_oh}, nmi ? 0 : (1 << id));
    chk({tag, " R5 nmi_ack"}, {31'd0, nmi_ack}, {31'd0, nmi});
  endtask

  task automatic give_vec(input logic [VW-1:0] v);
    sb.push_back('{err: 1'b0, v: v});
    dev_vec_valid = 1'b1; dev_vec = v;
    tick();
    dev_vec_valid = 1'b0; dev_vec = '0;
    @(negedge clk);
    tick();
  endtask

  task automatic idle_check(input string tag, input int cycles);
    insn_boundary = 1'b1;
    repeat (cycles) tick();
    insn_boundary = 1'b0;
    @(negedge clk);
    chk(tag, {31'd0, irq_req}, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_req = '0; src_en = '1; nmi_req = 1'b0; cpu_prio = '0;
    insn_boundary = 1'b0; cpu_ack = 1'b0; dev_vec_valid = 1'b0; dev_vec = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    @(negedge clk);
    // R10
    chk("R10 reset outputs", {irq_req, nmi_ack, dev_ack_oh, vec_valid, bus_err}, 0);
    tick();

    // R9 + R7: pulse held, nothing offered without boundary
    pulse(4'b0010, 1'b0);
    repeat (6) tick();
    @(negedge clk);
    chk("R7 no boundary no offer", {31'd0, irq_req}, 0);
    take("R9 latched pulse", 1, 1'b0);
    give_vec(8'h21);

    // R1: three-way contention drained in priority order
    pulse(4'b1101, 1'b0);
    take("R1 first", 3, 1'b0);  give_vec(8'h33);
    take("R1 second", 2, 1'b0); give_vec(8'h32);
    take("R1 third", 0, 1'b0);  give_vec(8'h30);

    // R2: source 1 (level 2) masked at cpu_prio 3, offered at 1
    cpu_prio = 3'd3;
    pulse(4'b0010, 1'b0);
    idle_check("R2 masked source not offered", 3);
    cpu_prio = 3'd1;
    take("R2 unmasked", 1, 1'b0); give_vec(8'h41);
    cpu_prio = 3'd0;

    // R4: disabled source ignored; disabling drops a pending request
    src_en = 4'b1011;
    pulse(4'b0100, 1'b0);
    src_en = '1;
    idle_check("R4 request on disabled source", 2);
    pulse(4'b0010, 1'b0);
    src_en = 4'b1101;
    tick();
    src_en = '1;
    idle_check("R4 pending dropped by disable", 2);

    // R3: NMI beats a pending source with everything masked and disabled
    pulse(4'b1000, 1'b1);
    cpu_prio = 3'd4; src_en = '0;
    take("R3 nmi first", 0, 1'b1); give_vec(8'hF0);
    cpu_prio = 3'd0; src_en = '1;
    pulse(4'b1000, 1'b0);
    take("R3 source after nmi", 3, 1'b0); give_vec(8'h13);

    // R6: timeout raises bus error, request stays pending and retries
    pulse(4'b0001, 1'b0);
    take("R6 timeout grant", 0, 1'b0);
    sb.push_back('{err: 1'b1, v: '0});
    repeat (TMO) tick();
    @(negedge clk);
    tick();
    chk("R6 bus error observed", sb.size(), 0);
    chk("R6 back to idle", {31'd0, irq_req | dev_ack_oh[0]}, 0);
    take("R6 retry after error", 0, 1'b0); give_vec(8'h10);

    idle_check("R8 request cleared after vector", 2);
    chk("R8 scoreboard drained", sb.size(), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule